// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the always-on controller that decides which power state the chip occupies and drives the enable, gating and retention controls for every clock and power domain. Software arms it with three control levels (sleep enable, deep-sleep enable, dream enable) and then issues a wait-for-interrupt strobe from the CPU. The sequencer looks at those levels, at whether the RTC or the deep-sleep watchdog is enabled, and at whether the radio reports that it is asleep. From these it moves from Run into Idle, Sleep, Deep Sleep or eXtreme Deep Sleep, or it refuses the request and stays in Run.

Each low-power state accepts only its own set of wake sources. A sub-state called Dream can only be reached from Sleep. In Dream the peripheral domains come on for on-demand work and then fall back to Sleep. Leaving either deep state counts as a power-on-style restart: the block pulses a restart output, records the kind of deep exit in a reset-cause field, and drops the regulator select back to the linear (LDO) setting. The regulator select moves to the buck setting only when software writes it. Every domain output is registered. On any wake, the clocks are switched back on one cycle before the mode code reports Run.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `mode` is 0 (Run) and the domain outputs hold their Run values: `clk_en`=4'hF, `mem_on`=2'b11, `mem_ret`=2'b00, `osc_en`=4'hF, `aon_en`=2'b11. Also `reg_buck`=0 (LDO), `wake_cause`=0, `reset_cause`=0 and `restart_pulse`=0.
- R2: In Run, a `wfi_strobe` with `sleep_en`=0 and `deep_en`=0 and no pending interrupt moves the block to Idle (mode 1) at the next edge. In Idle, `clk_en`=4'hE (only the CPU clock, bit 0, is gated), `mem_on`=2'b11, `mem_ret`=0, `osc_en`=4'hF and `aon_en`=2'b11. The `clk_en` bits are cpu=0, peripheral=1, flash=2, radio=3. The `osc_en` bits are crystal=0, PLL=1, fast RC=2, low-power RC=3.
- R3: A `wfi_strobe` with `sleep_en`=1, `deep_en`=0 and `radio_asleep`=1 moves Run to Sleep (mode 3). In Sleep, `clk_en`=0 and `mem_on`=0. `mem_ret`=2'b11 (bit 0 is core memory, bit 1 is backup RAM). `osc_en`=4'h9 (crystal and low-power RC only) and `aon_en`=2'b11. Each domain is never both on and in retention.
- R4: A `wfi_strobe` with `deep_en`=1 and `radio_asleep`=1 enters Deep Sleep (mode 4) if `rtc_en` or `dswdt_en` is set. If both are clear it enters eXtreme Deep Sleep (mode 5). Deep Sleep gives `clk_en`=0, `mem_on`=0, `mem_ret`=2'b10, `osc_en`=4'h8 and `aon_en`=2'b11 (bit 0 is RTC, bit 1 is deep watchdog). eXtreme Deep Sleep gives all zero except `osc_en`=4'h8.
- R5: A `wfi_strobe` is refused and the block stays in Run with unchanged outputs in three cases: any bit of `irq_pend` is set, `deep_en`=1 with the radio awake, or `sleep_en`=1 and `deep_en`=0 with the radio awake.
- R6: Idle and Sleep wake on any `irq_pend` bit or on `misc_wake`. `periph_event` and `periph_done` have no effect in Idle.
- R7: Deep Sleep wakes only on `int0_wake`, on `rtc_event` while `rtc_en`=1, or on `dswdt_event` while `dswdt_en`=1. `irq_pend` and `misc_wake` are ignored there.
- R8: eXtreme Deep Sleep wakes only on `int0_wake`. The RTC and watchdog events, `irq_pend` and `misc_wake` are ignored.
- R9: Dream (mode 2) is entered only from Sleep, when `dream_en`=1 and `periph_event` arrives. With `dream_en`=0 the event is ignored. Dream has the Idle domain values. `periph_done` returns Dream to Sleep, and a wake source returns Dream to Run.
- R10: When a wake is accepted, the domain outputs take their Run values at the next edge while `mode` still shows the old state. `mode` becomes 0 one edge later.
- R11: On the edge where `mode` returns to 0 from Deep Sleep or eXtreme Deep Sleep, `restart_pulse` is high for one cycle and `reset_cause` becomes 1 (Deep Sleep) or 2 (eXtreme Deep Sleep). A wake from Idle, Sleep or Dream leaves `reset_cause` unchanged. Reset sets it to 0 (power-up).
- R12: `reg_buck` changes only when `reg_wr`=1, taking the value of `reg_wr_buck`. It returns to 0 on a deep-state restart.
- R13: On the edge that accepts a wake, `wake_cause` is loaded with 1=interrupt, 2=misc event, 3=INT0, 4=RTC or 5=deep watchdog. Interrupt has priority over misc. INT0 has priority over RTC, and RTC over watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low power-on reset |
| wfi_strobe | input | 1 | One-cycle wait-for-interrupt from the CPU |
| sleep_en | input | 1 | Sleep enable control level |
| deep_en | input | 1 | Deep-sleep enable control level |
| dream_en | input | 1 | Dream sub-state enable |
| rtc_en | input | 1 | RTC is enabled |
| dswdt_en | input | 1 | Deep-sleep watchdog is enabled |
| radio_asleep | input | 1 | Radio reports its low-power state |
| irq_pend | input | NUM_IRQ | Enabled and pending interrupts |
| misc_wake | input | 1 | Other wake events (watchdogs, voltage detect, debug) |
| int0_wake | input | 1 | External INT0 wake |
| rtc_event | input | 1 | RTC alarm event |
| dswdt_event | input | 1 | Deep watchdog time-out event |
| periph_event | input | 1 | Peripheral request for on-demand activity |
| periph_done | input | 1 | On-demand activity finished |
| reg_wr | input | 1 | Write strobe for the regulator select |
| reg_wr_buck | input | 1 | Write data: 1 selects buck |
| mode | output | 3 | Current mode: 0 Run, 1 Idle, 2 Dream, 3 Sleep, 4 Deep, 5 eXtreme Deep |
| clk_en | output | 4 | Clock enables: cpu, peripheral, flash, radio |
| mem_on | output | 2 | Power on: core memory, backup RAM |
| mem_ret | output | 2 | Retention: core memory, backup RAM |
| osc_en | output | 4 | Oscillator enables: crystal, PLL, fast RC, low-power RC |
| aon_en | output | 2 | Always-on timer power: RTC, deep watchdog |
| reg_buck | output | 1 | Regulator select, 0 is LDO |
| wake_cause | output | 3 | Source of the last accepted wake |
| reset_cause | output | 2 | 0 power-up, 1 Deep Sleep exit, 2 eXtreme Deep exit |
| restart_pulse | output | 1 | One-cycle restart request after a deep exit |

## Verification
The assertions assume that the control levels and the RTC and watchdog enables stay stable for a whole low-power episode. They also assume that `irq_pend` is already masked by the interrupt controller, and that event inputs are single-cycle pulses or levels sampled at the clock edge. The bench drives every input on the falling edge. It holds the configuration from before the strobe until the wake has completed, and raises one wake source at a time, except in the case that tests wake-cause priority. Reset is applied only between complete sequences, apart from one directed case that checks a reset taken from Sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int MODE_W  = 3;
  localparam int CAUSE_W = 3;
  localparam int RCAU_W  = 2;
  localparam int NCLK    = 4;
  localparam int NMEM    = 2;
  localparam int NOSC    = 4;
  localparam int NAON    = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN   = 3'd0,
    M_IDLE  = 3'd1,
    M_DREAM = 3'd2,
    M_SLEEP = 3'd3,
    M_DEEP  = 3'd4,
    M_XDS   = 3'd5
  } pmode_e;

  typedef enum logic [CAUSE_W-1:0] {
    WC_NONE  = 3'd0,
    WC_IRQ   = 3'd1,
    WC_MISC  = 3'd2,
    WC_INT0  = 3'd3,
    WC_RTC   = 3'd4,
    WC_DSWDT = 3'd5
  } wcause_e;

  typedef enum logic [RCAU_W-1:0] {
    RC_POWERUP = 2'd0,
    RC_DEEP    = 2'd1,
    RC_XDS     = 2'd2
  } rcause_e;

  typedef struct packed {
    logic [NCLK-1:0] clk;
    logic [NMEM-1:0] on;
    logic [NMEM-1:0] ret;
    logic [NOSC-1:0] osc;
    logic [NAON-1:0] aon;
  } dom_t;

  // Per-state domain settings; Dream keeps its on-demand domains powered.
  function automatic dom_t dom_of(pmode_e m);
    dom_t d;
    d = '0;
    d.osc[3] = 1'b1;
    case (m)
      M_RUN: begin
        d.clk = 4'hF; d.on = 2'b11; d.osc = 4'hF; d.aon = 2'b11;
      end
      M_IDLE, M_DREAM: begin
        d.clk = 4'hE; d.on = 2'b11; d.osc = 4'hF; d.aon = 2'b11;
      end
      M_SLEEP: begin
        d.ret = 2'b11; d.osc = 4'h9; d.aon = 2'b11;
      end
      M_DEEP: begin
        d.ret = 2'b10; d.aon = 2'b11;
      end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lpm_entry_sel.sv
module lpm_entry_sel
  import lpm_pkg::*;
(
  input  logic   wfi,
  input  logic   sleep_en,
  input  logic   deep_en,
  input  logic   rtc_en,
  input  logic   dswdt_en,
  input  logic   radio_asleep,
  input  logic   irq_any,
  output logic   enter,
  output pmode_e target
);

  // Deep enable takes precedence; a pending interrupt vetoes any entry.
  always_comb begin
    enter  = 1'b0;
    target = M_RUN;
    if (wfi && !irq_any) begin
      if (deep_en) begin
        if (radio_asleep) begin
          enter  = 1'b1;
          target = (rtc_en || dswdt_en) ? M_DEEP : M_XDS;
        end
      end else if (sleep_en) begin
        if (radio_asleep) begin
          enter  = 1'b1;
          target = M_SLEEP;
        end
      end else begin
        enter  = 1'b1;
        target = M_IDLE;
      end
    end
  end

endmodule

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
  import lpm_pkg::*;
(
  input  pmode_e  mode,
  input  logic    irq_any,
  input  logic    misc_wake,
  input  logic    int0_wake,
  input  logic    rtc_event,
  input  logic    rtc_en,
  input  logic    dswdt_event,
  input  logic    dswdt_en,
  input  logic    dream_en,
  input  logic    periph_event,
  input  logic    periph_done,
  output logic    wake,
  output wcause_e cause,
  output logic    go_dream,
  output logic    go_sleep
);

  logic light_hit, deep_hit, rtc_hit, wdt_hit;

  assign rtc_hit   = rtc_event && rtc_en;
  assign wdt_hit   = dswdt_event && dswdt_en;
  assign light_hit = irq_any || misc_wake;
  assign deep_hit  = int0_wake || rtc_hit || wdt_hit;

  always_comb begin
    wake     = 1'b0;
    cause    = WC_NONE;
    go_dream = 1'b0;
    go_sleep = 1'b0;
    case (mode)
      M_IDLE, M_SLEEP, M_DREAM: begin
        wake  = light_hit;
        cause = irq_any ? WC_IRQ : WC_MISC;
        if (mode == M_SLEEP) go_dream = dream_en && periph_event;
        if (mode == M_DREAM) go_sleep = periph_done;
      end
      M_DEEP: begin
        wake  = deep_hit;
        cause = int0_wake ? WC_INT0 : (rtc_hit ? WC_RTC : WC_DSWDT);
      end
      M_XDS: begin
        wake  = int0_wake;
        cause = WC_INT0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_domain_reg.sv
module lpm_domain_reg
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  dom_t dom_d,
  output dom_t dom_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dom_q <= dom_of(M_RUN);
    else if (load) dom_q <= dom_d;
  end

  // A domain is either powered or held in retention, never both.
  assert_on_ret_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_q.on & dom_q.ret) == '0);

  // The CPU clock never runs without the low-power RC present.
  assert_cpu_needs_lprc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dom_q.clk[0] |-> dom_q.osc[3]);

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_strobe,
  input  logic               sleep_en,
  input  logic               deep_en,
  input  logic               dream_en,
  input  logic               rtc_en,
  input  logic               dswdt_en,
  input  logic               radio_asleep,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic               misc_wake,
  input  logic               int0_wake,
  input  logic               rtc_event,
  input  logic               dswdt_event,
  input  logic               periph_event,
  input  logic               periph_done,
  input  logic               reg_wr,
  input  logic               reg_wr_buck,
  output logic [MODE_W-1:0]  mode,
  output logic [NCLK-1:0]    clk_en,
  output logic [NMEM-1:0]    mem_on,
  output logic [NMEM-1:0]    mem_ret,
  output logic [NOSC-1:0]    osc_en,
  output logic [NAON-1:0]    aon_en,
  output logic               reg_buck,
  output logic [CAUSE_W-1:0] wake_cause,
  output logic [RCAU_W-1:0]  reset_cause,
  output logic               restart_pulse
);

  pmode_e  mode_q, mode_d, target;
  wcause_e wc_q, wc_d, cause;
  rcause_e rc_q, rc_d;
  logic    waking_q, waking_d;
  logic    restart_q, restart_d;
  logic    buck_q, buck_d;
  logic    irq_any, enter, wake, go_dream, go_sleep;
  logic    dom_load;
  dom_t    dom_d, dom_q;

  assign irq_any = |irq_pend;

  lpm_entry_sel u_entry (
    .wfi          (wfi_strobe),
    .sleep_en     (sleep_en),
    .deep_en      (deep_en),
    .rtc_en       (rtc_en),
    .dswdt_en     (dswdt_en),
    .radio_asleep (radio_asleep),
    .irq_any      (irq_any),
    .enter        (enter),
    .target       (target)
  );

  lpm_wake_sel u_wake (
    .mode         (mode_q),
    .irq_any      (irq_any),
    .misc_wake    (misc_wake),
    .int0_wake    (int0_wake),
    .rtc_event    (rtc_event),
    .rtc_en       (rtc_en),
    .dswdt_event  (dswdt_event),
    .dswdt_en     (dswdt_en),
    .dream_en     (dream_en),
    .periph_event (periph_event),
    .periph_done  (periph_done),
    .wake         (wake),
    .cause        (cause),
    .go_dream     (go_dream),
    .go_sleep     (go_sleep)
  );

  lpm_domain_reg u_dom (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dom_load),
    .dom_d (dom_d),
    .dom_q (dom_q)
  );

  // Wake runs in two steps: domains return first, the mode code follows.
  always_comb begin
    mode_d    = mode_q;
    waking_d  = waking_q;
    wc_d      = wc_q;
    rc_d      = rc_q;
    restart_d = 1'b0;
    buck_d    = reg_wr ? reg_wr_buck : buck_q;
    dom_load  = 1'b0;
    dom_d     = dom_of(mode_q);
    if (waking_q) begin
      mode_d   = M_RUN;
      waking_d = 1'b0;
      if (mode_q == M_DEEP || mode_q == M_XDS) begin
        restart_d = 1'b1;
        rc_d      = (mode_q == M_DEEP) ? RC_DEEP : RC_XDS;
        buck_d    = 1'b0;
      end
    end else if (mode_q == M_RUN) begin
      if (enter) begin
        mode_d   = target;
        dom_load = 1'b1;
        dom_d    = dom_of(target);
      end
    end else if (wake) begin
      waking_d = 1'b1;
      wc_d     = cause;
      dom_load = 1'b1;
      dom_d    = dom_of(M_RUN);
    end else if (go_dream) begin
      mode_d   = M_DREAM;
      dom_load = 1'b1;
      dom_d    = dom_of(M_DREAM);
    end else if (go_sleep) begin
      mode_d   = M_SLEEP;
      dom_load = 1'b1;
      dom_d    = dom_of(M_SLEEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_RUN;
      waking_q  <= 1'b0;
      wc_q      <= WC_NONE;
      rc_q      <= RC_POWERUP;
      restart_q <= 1'b0;
      buck_q    <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      waking_q  <= waking_d;
      wc_q      <= wc_d;
      rc_q      <= rc_d;
      restart_q <= restart_d;
      buck_q    <= buck_d;
    end
  end

  assign mode          = mode_q;
  assign clk_en        = dom_q.clk;
  assign mem_on        = dom_q.on;
  assign mem_ret       = dom_q.ret;
  assign osc_en        = dom_q.osc;
  assign aon_en        = dom_q.aon;
  assign reg_buck      = buck_q;
  assign wake_cause    = wc_q;
  assign reset_cause   = rc_q;
  assign restart_pulse = restart_q;

  assert_abort_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && wfi_strobe && irq_any) |=> (mode_q == M_RUN));

  assert_deep_wake_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DEEP && !waking_q && !int0_wake && !rtc_event && !dswdt_event)
      |=> (mode_q == M_DEEP && !waking_q));

  assert_xds_int0_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_XDS && !waking_q && !int0_wake) |=> (mode_q == M_XDS && !waking_q));

  assert_dream_from_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_SLEEP && mode_q != M_DREAM) |=> (mode_q != M_DREAM));

  assert_clk_before_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_RUN && !clk_en[0]) |=> (mode_q != M_RUN));

  assert_restart_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> (rc_q != RC_POWERUP && mode_q == M_RUN));

  assert_restart_ldo_R12: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> !buck_q);

endmodule

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_strobe = 0, sleep_en = 0, deep_en = 0, dream_en = 0;
  logic       rtc_en = 0, dswdt_en = 0, radio_asleep = 0;
  logic [7:0] irq_pend = '0;
  logic       misc_wake = 0, int0_wake = 0, rtc_event = 0, dswdt_event = 0;
  logic       periph_event = 0, periph_done = 0, reg_wr = 0, reg_wr_buck = 0;
  logic [2:0] mode;
  logic [3:0] clk_en, osc_en;
  logic [1:0] mem_on, mem_ret, aon_en, reset_cause;
  logic       reg_buck, restart_pulse;
  logic [2:0] wake_cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_sequencer #(.NUM_IRQ(8)) i_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .wfi_strobe(wfi_strobe), .sleep_en(sleep_en),
    .deep_en(deep_en), .dream_en(dream_en), .rtc_en(rtc_en), .dswdt_en(dswdt_en),
    .radio_asleep(radio_asleep), .irq_pend(irq_pend), .misc_wake(misc_wake),
    .int0_wake(int0_wake), .rtc_event(rtc_event), .dswdt_event(dswdt_event),
    .periph_event(periph_event), .periph_done(periph_done), .reg_wr(reg_wr),
    .reg_wr_buck(reg_wr_buck), .mode(mode), .clk_en(clk_en), .mem_on(mem_on),
    .mem_ret(mem_ret), .osc_en(osc_en), .aon_en(aon_en), .reg_buck(reg_buck),
    .wake_cause(wake_cause), .reset_cause(reset_cause), .restart_pulse(restart_pulse)
  );

  typedef struct packed {
    logic       sl, dp, rtc, wdt, radio, irq;
    logic [2:0] src;
    logic [2:0] emode;
    logic [3:0] eclk;
    logic [3:0] eosc;
    logic [1:0] eret;
    logic [1:0] eaon;
    logic [2:0] ecause;
    logic [1:0] erc;
  } vec_t;

  localparam int NV = 9;
  // src: 0 none, 1 irq, 2 misc, 3 int0, 4 rtc, 5 deep watchdog
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1, 3'd1, 4'hE, 4'hF, 2'd0, 2'd3, 3'd1, 2'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 3'd2, 3'd3, 4'h0, 4'h9, 2'd3, 2'd3, 3'd2, 2'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 3'd4, 3'd4, 4'h0, 4'h8, 2'd2, 2'd3, 3'd4, 2'd1},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 3'd5, 3'd4, 4'h0, 4'h8, 2'd2, 2'd3, 3'd5, 2'd1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 3'd3, 3'd5, 4'h0, 4'h8, 2'd0, 2'd0, 3'd3, 2'd2},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 3'd3, 3'd4, 4'h0, 4'h8, 2'd2, 2'd3, 3'd3, 2'd1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 3'd0, 3'd0, 4'hF, 4'hF, 2'd0, 2'd3, 3'd0, 2'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 3'd0, 4'hF, 4'hF, 2'd0, 2'd3, 3'd0, 2'd0},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'd0, 3'd0, 4'hF, 4'hF, 2'd0, 2'd3, 3'd0, 2'd0}
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic drive_src(input logic [2:0] s, input logic v);
    case (s)
      3'd1: irq_pend[0] = v;
      3'd2: misc_wake   = v;
      3'd3: int0_wake   = v;
      3'd4: rtc_event   = v;
      3'd5: dswdt_event = v;
      default: ;
    endcase
  endtask

  task automatic clear_cfg();
    sleep_en = 0; deep_en = 0; dream_en = 0; rtc_en = 0; dswdt_en = 0;
    radio_asleep = 0; irq_pend = '0;
  endtask

  task automatic wfi_pulse();
    wfi_strobe = 1;
    @(negedge clk);
    wfi_strobe = 0;
  endtask

  // One source pulse, then the wake step, then Run.
  task automatic wake_via(input logic [2:0] s);
    drive_src(s, 1'b1);
    @(negedge clk);
    drive_src(s, 1'b0);
    @(negedge clk);
  endtask

  task automatic check_run_doms(input string tag);
    check({tag, " clk_en"}, 32'(clk_en), 32'hF);
    check({tag, " mem_on"}, 32'(mem_on), 32'h3);
    check({tag, " mem_ret"}, 32'(mem_ret), 32'h0);
    check({tag, " osc_en"}, 32'(osc_en), 32'hF);
    check({tag, " aon_en"}, 32'(aon_en), 32'h3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", 32'(mode), 32'd0);
    check_run_doms("R1");
    check("R1 reg_buck", 32'(reg_buck), 32'd0);
    check("R1 wake_cause", 32'(wake_cause), 32'd0);
    check("R1 reset_cause", 32'(reset_cause), 32'd0);
    check("R1 restart", 32'(restart_pulse), 32'd0);

    // Table walk covering R2 R3 R4 R5 R10 R11 R13
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      sleep_en = v.sl; deep_en = v.dp; rtc_en = v.rtc; dswdt_en = v.wdt;
      radio_asleep = v.radio; irq_pend = {7'd0, v.irq};
      wfi_pulse();
      irq_pend = '0;
      check($sformatf("R2/R3/R4/R5 vec%0d mode", i), 32'(mode), 32'(v.emode));
      check($sformatf("R2/R3/R4/R5 vec%0d clk_en", i), 32'(clk_en), 32'(v.eclk));
      check($sformatf("R2/R3/R4 vec%0d osc_en", i), 32'(osc_en), 32'(v.eosc));
      check($sformatf("R3/R4 vec%0d mem_ret", i), 32'(mem_ret), 32'(v.eret));
      check($sformatf("R4 vec%0d aon_en", i), 32'(aon_en), 32'(v.eaon));
      if (v.src != 3'd0) begin
        drive_src(v.src, 1'b1);
        @(negedge clk);
        drive_src(v.src, 1'b0);
        check($sformatf("R10 vec%0d mode held", i), 32'(mode), 32'(v.emode));
        check($sformatf("R10 vec%0d clocks early", i), 32'(clk_en), 32'hF);
        check($sformatf("R13 vec%0d wake_cause", i), 32'(wake_cause), 32'(v.ecause));
        @(negedge clk);
        check($sformatf("R10 vec%0d mode run", i), 32'(mode), 32'd0);
        check($sformatf("R11 vec%0d restart", i), 32'(restart_pulse), 32'(v.emode >= 3'd4));
        check($sformatf("R11 vec%0d reset_cause", i), 32'(reset_cause), 32'(v.erc));
        @(negedge clk);
        check($sformatf("R11 vec%0d restart one cycle", i), 32'(restart_pulse), 32'd0);
      end
      clear_cfg();
      @(negedge clk);
    end

    // R5: no strobe, no change
    sleep_en = 1; radio_asleep = 1;
    repeat (2) @(negedge clk);
    check("R5 no strobe", 32'(mode), 32'd0);
    clear_cfg();

    // R6: Idle ignores peripheral traffic
    wfi_pulse();
    periph_event = 1; periph_done = 1;
    @(negedge clk);
    periph_event = 0; periph_done = 0;
    @(negedge clk);
    check("R6 idle periph ignored", 32'(mode), 32'd1);
    wake_via(3'd2);
    check("R6 idle misc wake", 32'(mode), 32'd0);

    // R7: Deep ignores irq, misc and a disabled watchdog
    deep_en = 1; rtc_en = 1; radio_asleep = 1;
    wfi_pulse();
    irq_pend = 8'h80; misc_wake = 1; dswdt_event = 1;
    @(negedge clk);
    irq_pend = '0; misc_wake = 0; dswdt_event = 0;
    @(negedge clk);
    check("R7 deep ignores", 32'(mode), 32'd4);
    check("R7 deep clocks off", 32'(clk_en), 32'h0);
    // R13 priority: INT0 over RTC
    int0_wake = 1; rtc_event = 1;
    @(negedge clk);
    int0_wake = 0; rtc_event = 0;
    check("R13 int0 priority", 32'(wake_cause), 32'd3);
    @(negedge clk);
    check("R11 deep restart", 32'(restart_pulse), 32'd1);
    clear_cfg();

    // R8: XDS ignores everything except INT0
    deep_en = 1; radio_asleep = 1;
    wfi_pulse();
    rtc_event = 1; dswdt_event = 1; irq_pend = 8'h01; misc_wake = 1;
    @(negedge clk);
    rtc_event = 0; dswdt_event = 0; irq_pend = '0; misc_wake = 0;
    @(negedge clk);
    check("R8 xds ignores", 32'(mode), 32'd5);
    check("R8 xds aon off", 32'(aon_en), 32'd0);
    wake_via(3'd3);
    check("R8 xds int0 exit", 32'(mode), 32'd0);
    check("R11 xds cause", 32'(reset_cause), 32'd2);
    clear_cfg();
    @(negedge clk);

    // R9: Dream only when enabled, returns to Sleep, wakes to Run
    sleep_en = 1; radio_asleep = 1;
    wfi_pulse();
    periph_event = 1;
    @(negedge clk);
    periph_event = 0;
    check("R9 dream disabled", 32'(mode), 32'd3);
    dream_en = 1;
    periph_event = 1;
    @(negedge clk);
    periph_event = 0;
    check("R9 dream entered", 32'(mode), 32'd2);
    check("R9 dream clk_en", 32'(clk_en), 32'hE);
    check("R9 dream mem_on", 32'(mem_on), 32'h3);
    periph_done = 1;
    @(negedge clk);
    periph_done = 0;
    check("R9 dream to sleep", 32'(mode), 32'd3);
    check("R9 sleep mem_ret", 32'(mem_ret), 32'h3);
    periph_event = 1;
    @(negedge clk);
    periph_event = 0;
    check("R9 dream again", 32'(mode), 32'd2);
    wake_via(3'd1);
    check("R9 dream wake run", 32'(mode), 32'd0);
    check("R11 light wake keeps cause", 32'(reset_cause), 32'd2);
    check("R13 dream irq cause", 32'(wake_cause), 32'd1);
    clear_cfg();

    // R12: buck select by write, kept over light wake, cleared by deep exit
    reg_wr = 1; reg_wr_buck = 1;
    @(negedge clk);
    reg_wr = 0; reg_wr_buck = 0;
    check("R12 buck written", 32'(reg_buck), 32'd1);
    wfi_pulse();
    wake_via(3'd1);
    check("R12 buck kept", 32'(reg_buck), 32'd1);
    deep_en = 1; dswdt_en = 1; radio_asleep = 1;
    wfi_pulse();
    wake_via(3'd5);
    check("R12 buck cleared", 32'(reg_buck), 32'd0);
    check("R11 deep cause", 32'(reset_cause), 32'd1);
    clear_cfg();

    // R1 reset from Sleep
    sleep_en = 1; radio_asleep = 1;
    wfi_pulse();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    clear_cfg();
    @(negedge clk);
    check("R1 reset mode", 32'(mode), 32'd0);
    check_run_doms("R1 after reset");
    check("R1 reset_cause powerup", 32'(reset_cause), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule